// File: doc/BRIEF.md
# Synthesizer Divider Chain with Test Selector

This block is the digital divider chain of a frequency synthesizer. One fast system clock runs all of its logic. The oscillator, the crystal reference and the slow serial clock reach it as single-cycle strobes. Each strobe marks one edge of the clock it stands for, so one full period of that clock is two strobes.

The chain has three dividers:
- A reference prescaler divides the crystal by 16.
- A programmable feedback divider produces the oscillator divided by M and then by a further 2. This is the comparison clock that makes the oscillator settle at 2·M times the reference.
- An output divider produces FOUT with a 50% duty cycle, using a two-bit ratio code.

A three-bit test selector drives a TEST pin. Two of its codes move the feedback divider or the output divider from the oscillator onto the serial clock, so that the counters can be watched at low speed.

A new M or N value is picked up only when the divider concerned reaches terminal count. The half period in progress therefore always completes at the old ratio and no runt pulse appears. Source switching is a choice between strobes inside one clock domain, so a change of test code cannot cut an output pulse short.

Top module: `synth_div_chain`

## Requirements
- R1: While reset is high, FOUT, the prescaler output, the feedback output and the FOUT÷4 output are all low. With test code 000, TEST follows the shift-register bit.
- R2: Test code 010 shows the reference prescaler. Its output toggles on every 16th reference strobe, giving a period of 32 reference strobes (a divide by 16).
- R3: Test code 011 shows the feedback output. It toggles on every second terminal count of an M-strobe counter, giving a period of 4·M oscillator strobes. An M value of 0 behaves as 1.
- R4: FOUT toggles once every K strobes of its source, which gives a 50% duty cycle. K is 2 for ratio code 00, 4 for 01, 8 for 10 and 1 for 11.
- R5: A change of M or of the ratio code takes effect at the divider's next terminal count; the half period already running keeps the old ratio.
- R6: Test code 001 drives TEST high, code 101 drives it low, code 100 drives it with FOUT, and code 000 drives it with the shift-register bit.
- R7: Under test code 110, the feedback divider counts serial-clock strobes instead of oscillator strobes, and TEST shows its output.
- R8: Under test code 111, the output divider counts serial-clock strobes, and TEST shows FOUT÷4. This signal toggles on every second rising edge of FOUT.
- R9: A divider whose selected strobe is absent holds its output for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| vco_stb_i | input | 1 | Oscillator edge strobe |
| ref_stb_i | input | 1 | Crystal reference edge strobe |
| sck_stb_i | input | 1 | Serial clock edge strobe |
| shift_bit_i | input | 1 | Shift-register output bit |
| fb_div_i | input | 9 | Feedback ratio M |
| out_div_i | input | 2 | Output ratio code |
| test_sel_i | input | 3 | TEST source select |
| fout_o | output | 1 | Divided output clock |
| test_o | output | 1 | Test pin |

## Verification
The bench builds the block with its default widths: a 9-bit M and a 4-bit prescaler. These put the whole lock range, up to M = 350, within reach, together with the M = 0 corner. The bench measures output periods for every ratio code and for several M values. It also checks a ratio change in the middle of a half period. Slow-clock test codes are driven with a serial strobe on every third cycle, so that oscillator strobes are visibly ignored.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    localparam int N_CODE_W = 2;
    localparam int RATIO_W  = 4;
    localparam int SEL_W    = 3;

    typedef enum logic [SEL_W-1:0] {
        TS_SHIFT     = 3'd0,
        TS_HIGH      = 3'd1,
        TS_REF       = 3'd2,
        TS_FB        = 3'd3,
        TS_FOUT      = 3'd4,
        TS_LOW       = 3'd5,
        TS_FB_SLOW   = 3'd6,
        TS_FOUT_SLOW = 3'd7
    } test_sel_e;

    typedef struct packed {
        logic ref_div;
        logic fb_div;
        logic fout;
        logic fout_q;
    } taps_t;

    // ratio code is deliberately non-monotonic: 11 means divide by one
    function automatic logic [RATIO_W-1:0] out_ratio(input logic [N_CODE_W-1:0] code);
        case (code)
            2'b00:   return 4'd2;
            2'b01:   return 4'd4;
            2'b10:   return 4'd8;
            default: return 4'd1;
        endcase
    endfunction

endpackage

// File: rtl/sdc_ref_prescale.sv
module sdc_ref_prescale #(
    parameter int PRE_W = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic stb_i,
    output logic div_o
);
    logic [PRE_W-1:0] cnt;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt   <= '0;
            div_o <= 1'b0;
        end else if (stb_i) begin
            cnt <= cnt + 1'b1;
            if (&cnt) div_o <= ~div_o;
        end
    end
endmodule

// File: rtl/sdc_fb_divider.sv
module sdc_fb_divider #(
    parameter int M_W = 9
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic           stb_i,
    input  logic [M_W-1:0] m_i,
    output logic           div_o
);
    logic [M_W-1:0] rem;
    logic           phase;
    logic [M_W-1:0] load;

    assign load = (m_i == '0) ? M_W'(1) : m_i;

    // ratio is sampled only at terminal count; output toggles every 2nd one
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rem   <= '0;
            phase <= 1'b0;
            div_o <= 1'b0;
        end else if (stb_i) begin
            if (rem == '0) begin
                rem   <= load - M_W'(1);
                phase <= ~phase;
                if (phase) div_o <= ~div_o;
            end else begin
                rem <= rem - M_W'(1);
            end
        end
    end
endmodule

// File: rtl/sdc_out_divider.sv
module sdc_out_divider
    import sdc_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                stb_i,
    input  logic [N_CODE_W-1:0] code_i,
    output logic                fout_o,
    output logic                fout_q_o
);
    localparam int CNT_W = RATIO_W - 1;

    logic [CNT_W-1:0]   rem;
    logic [RATIO_W-1:0] ratio_m1;
    logic [1:0]         quarter;
    logic               rise;

    assign ratio_m1 = out_ratio(code_i) - 1'b1;
    assign rise     = stb_i && (rem == '0) && !fout_o;
    assign fout_q_o = quarter[1];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rem    <= '0;
            fout_o <= 1'b0;
        end else if (stb_i) begin
            if (rem == '0) begin
                rem    <= ratio_m1[CNT_W-1:0];
                fout_o <= ~fout_o;
            end else begin
                rem <= rem - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)     quarter <= '0;
        else if (rise) quarter <= quarter + 1'b1;
    end
endmodule

// File: rtl/synth_div_chain.sv
module synth_div_chain
    import sdc_pkg::*;
#(
    parameter int M_W   = 9,
    parameter int PRE_W = 4
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                vco_stb_i,
    input  logic                ref_stb_i,
    input  logic                sck_stb_i,
    input  logic                shift_bit_i,
    input  logic [M_W-1:0]      fb_div_i,
    input  logic [N_CODE_W-1:0] out_div_i,
    input  logic [SEL_W-1:0]    test_sel_i,
    output logic                fout_o,
    output logic                test_o
);
    test_sel_e sel;
    taps_t     taps;
    logic      fb_stb;
    logic      out_stb;

    assign sel     = test_sel_e'(test_sel_i);
    assign fb_stb  = (sel == TS_FB_SLOW)   ? sck_stb_i : vco_stb_i;
    assign out_stb = (sel == TS_FOUT_SLOW) ? sck_stb_i : vco_stb_i;

    sdc_ref_prescale #(.PRE_W(PRE_W)) u_ref (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .stb_i (ref_stb_i),
        .div_o (taps.ref_div)
    );

    sdc_fb_divider #(.M_W(M_W)) u_fb (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .stb_i (fb_stb),
        .m_i   (fb_div_i),
        .div_o (taps.fb_div)
    );

    sdc_out_divider u_out (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .stb_i    (out_stb),
        .code_i   (out_div_i),
        .fout_o   (taps.fout),
        .fout_q_o (taps.fout_q)
    );

    assign fout_o = taps.fout;

    always_comb begin
        case (sel)
            TS_SHIFT:   test_o = shift_bit_i;
            TS_HIGH:    test_o = 1'b1;
            TS_REF:     test_o = taps.ref_div;
            TS_FB,
            TS_FB_SLOW: test_o = taps.fb_div;
            TS_FOUT:    test_o = taps.fout;
            TS_LOW:     test_o = 1'b0;
            default:    test_o = taps.fout_q;
        endcase
    end
endmodule

// File: rtl/synth_div_chain_chk.sv
module synth_div_chain_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic       ref_stb_i,
    input logic       sck_stb_i,
    input logic       shift_bit_i,
    input logic [2:0] test_sel_i,
    input logic       fout_o,
    input logic       test_o,
    input logic       out_stb,
    input logic       ref_div,
    input logic       fb_div
);
    // R1
    a_r1_reset_low: assert property (@(posedge clk_i) rst_i |=> !fout_o && !fb_div && !ref_div);
    // R9
    a_r9_fout_hold: assert property (@(posedge clk_i) disable iff (rst_i) !out_stb |=> $stable(fout_o));
    // R2
    a_r2_ref_hold: assert property (@(posedge clk_i) disable iff (rst_i) !ref_stb_i |=> $stable(ref_div));
    // R6
    a_r6_high: assert property (@(posedge clk_i) disable iff (rst_i) test_sel_i == 3'd1 |-> test_o);
    a_r6_low: assert property (@(posedge clk_i) disable iff (rst_i) test_sel_i == 3'd5 |-> !test_o);
    a_r6_shift: assert property (@(posedge clk_i) disable iff (rst_i) test_sel_i == 3'd0 |-> test_o == shift_bit_i);
    // R7
    a_r7_slow_fb: assert property (@(posedge clk_i) disable iff (rst_i)
        (test_sel_i == 3'd6 && !sck_stb_i) |=> $stable(fb_div));
    // R8
    a_r8_slow_out: assert property (@(posedge clk_i) disable iff (rst_i)
        (test_sel_i == 3'd7 && !sck_stb_i) |=> $stable(fout_o));
endmodule

bind synth_div_chain synth_div_chain_chk u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .ref_stb_i   (ref_stb_i),
    .sck_stb_i   (sck_stb_i),
    .shift_bit_i (shift_bit_i),
    .test_sel_i  (test_sel_i),
    .fout_o      (fout_o),
    .test_o      (test_o),
    .out_stb     (out_stb),
    .ref_div     (taps.ref_div),
    .fb_div      (taps.fb_div)
);

// File: tb/sim_synth_div_chain.sv
module sim_synth_div_chain;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       vco_stb = 1'b0, ref_stb = 1'b0, sck_stb = 1'b0, shift_bit = 1'b0;
    logic [8:0] m = 9'd5;
    logic [1:0] n = 2'd0;
    logic [2:0] t = 3'd0;
    logic       fout, test;

    always #2 clk = ~clk;

    synth_div_chain u0 (
        .clk_i(clk), .rst_i(rst), .vco_stb_i(vco_stb), .ref_stb_i(ref_stb),
        .sck_stb_i(sck_stb), .shift_bit_i(shift_bit), .fb_div_i(m),
        .out_div_i(n), .test_sel_i(t), .fout_o(fout), .test_o(test)
    );

    int    checks = 0, errors = 0, cyc = 0;
    string tag = "R1";
    bit    vco_on = 1, ref_on = 1, done = 0;
    int    sck_gap = 3;

    // behavioural reference state
    int rc, refo, mrem, mtc, mo, nrem, fo, q4;

    function automatic int ratio_of(input logic [1:0] c);
        if (c == 2'd3) return 1;
        return 2 << c;
    endfunction

    function automatic int exp_test();
        case (t)
            3'd0: return int'(shift_bit);
            3'd1: return 1;
            3'd2: return refo;
            3'd3, 3'd6: return mo;
            3'd4: return fo;
            3'd5: return 0;
            default: return (q4 >= 2) ? 1 : 0;
        endcase
    endfunction

    task automatic chk(input string r, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d (cycle %0d)", r, act, expv, cyc);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            rc = 0; refo = 0; mrem = 0; mtc = 0; mo = 0; nrem = 0; fo = 0; q4 = 0;
        end else begin
            if (ref_stb) begin
                rc++;
                if (rc == 16) begin rc = 0; refo ^= 1; end
            end
            if ((t == 3'd6) ? sck_stb : vco_stb) begin
                if (mrem == 0) begin
                    mrem = ((m == 0) ? 1 : int'(m)) - 1;
                    mtc++;
                    if (mtc % 2 == 0) mo ^= 1;
                end else mrem--;
            end
            if ((t == 3'd7) ? sck_stb : vco_stb) begin
                if (nrem == 0) begin
                    nrem = ratio_of(n) - 1;
                    fo ^= 1;
                    if (fo == 1) q4 = (q4 + 1) % 4;
                end else nrem--;
            end
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            chk({tag, " fout"}, int'(fout), fo);
            chk({tag, " test"}, int'(test), exp_test());
        end
        vco_stb   = vco_on;
        ref_stb   = ref_on;
        sck_stb   = (sck_gap > 0) && (cyc % sck_gap == 0);
        shift_bit = cyc[3] ^ cyc[1];
        if (cyc > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog actual %0d expected below 150000", cyc);
            summary();
        end
    end

    task automatic period_of(input bit on_test, output int p);
        bit prev, cur;
        int k;
        p = -1;
        prev = on_test ? test : fout;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            cur = on_test ? test : fout;
            if (cur && !prev) break;
            prev = cur;
        end
        k = 0;
        prev = 1'b1;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            k++;
            cur = on_test ? test : fout;
            if (cur && !prev) begin p = k; break; end
            prev = cur;
        end
    endtask

    task automatic setcfg(input logic [8:0] mv, input logic [1:0] nv, input logic [2:0] tv);
        @(posedge clk); #1;
        m = mv; n = nv; t = tv;
    endtask

    initial begin
        int p;
        int k;
        bit held;
        repeat (3) @(negedge clk);
        // R1: reset state observed at the ports
        chk("R1 fout in reset", int'(fout), 0);
        chk("R1 test follows shift bit", int'(test), int'(shift_bit));
        @(posedge clk); #1 rst = 1'b0;

        // R4: each ratio code, vco strobe every cycle
        tag = "R4";
        for (int c = 0; c < 4; c++) begin
            setcfg(9'd5, c[1:0], 3'd4);
            period_of(1'b0, p);
            period_of(1'b0, p);
            chk("R4 fout period", p, 2 * ratio_of(c[1:0]));
        end

        // R3: feedback period 4*M, M=0 acts as 1
        tag = "R3";
        setcfg(9'd3, 2'd0, 3'd3); period_of(1'b1, p); period_of(1'b1, p);
        chk("R3 period M=3", p, 12);
        setcfg(9'd0, 2'd0, 3'd3); period_of(1'b1, p); period_of(1'b1, p);
        chk("R3 period M=0", p, 4);
        setcfg(9'd100, 2'd0, 3'd3); period_of(1'b1, p); period_of(1'b1, p);
        chk("R3 period M=100", p, 400);
        setcfg(9'd350, 2'd0, 3'd3); period_of(1'b1, p); period_of(1'b1, p);
        chk("R3 period M=350", p, 1400);

        // R5: M change mid-count, then follow model
        tag = "R5";
        repeat (37) @(negedge clk);
        setcfg(9'd7, 2'd0, 3'd3);
        repeat (200) @(negedge clk);

        // R2: prescaler
        tag = "R2";
        setcfg(9'd7, 2'd0, 3'd2); period_of(1'b1, p); period_of(1'b1, p);
        chk("R2 prescaler period", p, 32);

        // R6: fixed levels and pass-throughs
        tag = "R6";
        setcfg(9'd7, 2'd1, 3'd1); repeat (20) @(negedge clk);
        setcfg(9'd7, 2'd1, 3'd5); repeat (20) @(negedge clk);
        setcfg(9'd7, 2'd1, 3'd0); repeat (40) @(negedge clk);
        setcfg(9'd7, 2'd1, 3'd4); repeat (40) @(negedge clk);

        // R5: ratio change while FOUT is high keeps the old half period
        tag = "R5";
        setcfg(9'd7, 2'd2, 3'd4);
        period_of(1'b0, p);
        @(posedge clk); #1 n = 2'd3;
        k = 1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!fout) break;
            k++;
        end
        chk("R5 high time after ratio change", k, 8);
        repeat (30) @(negedge clk);

        // R9: no oscillator strobes, FOUT holds
        tag = "R9";
        vco_on = 0;
        @(negedge clk); held = fout;
        repeat (50) @(negedge clk);
        chk("R9 fout held without strobes", int'(fout), int'(held));
        vco_on = 1;

        // R7: feedback divider on serial strobe (every 3rd cycle)
        tag = "R7";
        setcfg(9'd4, 2'd3, 3'd6); period_of(1'b1, p); period_of(1'b1, p);
        chk("R7 slow feedback period", p, 4 * 4 * 3);

        // R8: output divider on serial strobe, TEST = FOUT/4
        tag = "R8";
        setcfg(9'd4, 2'd1, 3'd7); period_of(1'b0, p); period_of(1'b0, p);
        chk("R8 slow fout period", p, 2 * 4 * 3);
        period_of(1'b1, p);
        period_of(1'b1, p);
        chk("R8 fout/4 period", p, 4 * 2 * 4 * 3);

        done = 1;
        summary();
    end
endmodule